// File: doc/BRIEF.md
# Transfer Completion and Error Tagger

This block follows a single endpoint transfer descriptor from the moment it is loaded until the transfer ends. A load strobe sets the requested byte total, the direction, the isochronous attribute and the maximum packet size. After that, each accepted packet reduces the remaining count by the number of bytes actually moved. The rule that ends a transfer depends on direction. A transmit transfer ends only when the count reaches zero. A receive transfer also ends on a short packet, and in that case the residual count is left visible. The block emits a one-cycle completion pulse when a transfer ends.

Alongside the byte counting, the block sorts packet error strobes into two sticky flags: a data-buffer error and a transaction error. The direction and endpoint type select which flag, if any, an error strobe sets. An errored isochronous packet is never replayed. Its error is tagged, its bytes are still counted, and the transfer carries on. Both flags stay set until the next descriptor load.

Top module: `xdt_tagger`

## Requirements
- R1: Out of reset, `remaining`, `xfer_done`, `data_buf_err` and `trans_err` are 0. In the cycle after `load`, `remaining` equals `load_bytes`, both flags are 0 and `xfer_done` is 0.
- R2: A packet (`pkt_valid`) accepted during an active transfer whose `pkt_bytes` does not exceed `remaining` lowers `remaining` by `pkt_bytes` in the next cycle.
- R3: When `load_rx`=0 (transmit), `xfer_done` is raised only for the packet that brings `remaining` to zero. Packets shorter than the maximum packet size do not end a transmit transfer.
- R4: When `load_rx`=1 (receive), a packet with `pkt_bytes` < `load_max_pkt` ends the transfer and leaves the residual count in `remaining`. A receive transfer also ends when `remaining` reaches zero.
- R5: `xfer_done` is high for exactly one cycle. After completion, packets are ignored (`remaining` holds and no new pulse occurs) until the next `load`.
- R6: A packet larger than `remaining` drives `remaining` to 0, sets `data_buf_err` and ends the transfer, in either direction.
- R7: `ev_overflow` on a receive descriptor sets `data_buf_err` and leaves `trans_err` clear. On a transmit descriptor it has no effect.
- R8: `ev_iso_pkt_err` on a receive isochronous descriptor (`load_iso`=1) sets `trans_err` only. It has no effect on non-isochronous or transmit descriptors.
- R9: `ev_iso_fulfill_err` on an isochronous descriptor of either direction sets `trans_err` only. It has no effect on non-isochronous descriptors.
- R10: Both flags are sticky until the next `load`. A `load` that arrives in the same cycle as an error strobe wins, and both flags read 0 afterwards.
- R11: An isochronous error strobe in the same cycle as a packet does not hold back that packet. Its bytes are counted, and it may end the transfer in the same cycle that the error is tagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Descriptor load strobe |
| load_bytes | input | CNT_W (15) | Requested byte total |
| load_rx | input | 1 | 1 = receive, 0 = transmit |
| load_iso | input | 1 | 1 = isochronous endpoint |
| load_max_pkt | input | PKT_W (11) | Maximum packet size |
| pkt_valid | input | 1 | One packet finished this cycle |
| pkt_bytes | input | PKT_W (11) | Bytes actually moved by the packet |
| ev_overflow | input | 1 | Data buffer overflow strobe |
| ev_iso_pkt_err | input | 1 | Isochronous packet error strobe |
| ev_iso_fulfill_err | input | 1 | Isochronous fulfillment error strobe |
| remaining | output | CNT_W (15) | Remaining byte count |
| xfer_done | output | 1 | One-cycle completion pulse |
| data_buf_err | output | 1 | Sticky data-buffer error flag |
| trans_err | output | 1 | Sticky transaction error flag |

## Verification
Two functions can fall in the same cycle: the packet that ends a transfer, and an isochronous error strobe that tags that same packet. The bench drives `pkt_valid` and `ev_iso_pkt_err` or `ev_iso_fulfill_err` together. In the following cycle it expects the completion pulse, the updated count and the transaction flag all at once. It also fires a descriptor load together with an overflow strobe and expects the load to win, leaving both flags clear.

// File: rtl/xdt_pkg.sv
package xdt_pkg;

   localparam int unsigned N_ERR = 3;

   typedef enum int unsigned {
      ERR_OVERFLOW  = 0,
      ERR_ISO_PKT   = 1,
      ERR_ISO_FULL  = 2
   } err_src_e;

   typedef struct packed {
      logic on_rx;
      logic on_tx;
      logic iso_only;
      logic to_dbe;
      logic to_txe;
   } err_rule_t;

   function automatic err_rule_t xdt_rule(int unsigned idx);
      err_rule_t r;
      r = '0;
      case (idx)
         ERR_OVERFLOW: r = '{on_rx: 1'b1, on_tx: 1'b0, iso_only: 1'b0, to_dbe: 1'b1, to_txe: 1'b0};
         ERR_ISO_PKT:  r = '{on_rx: 1'b1, on_tx: 1'b0, iso_only: 1'b1, to_dbe: 1'b0, to_txe: 1'b1};
         ERR_ISO_FULL: r = '{on_rx: 1'b1, on_tx: 1'b1, iso_only: 1'b1, to_dbe: 1'b0, to_txe: 1'b1};
         default:      r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/xdt_countdown.sv
module xdt_countdown #(
   parameter int unsigned CNT_W = 15,
   parameter int unsigned PKT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_bytes,
   input  logic             load_rx,
   input  logic             load_iso,
   input  logic [PKT_W-1:0] load_max_pkt,
   input  logic             pkt_valid,
   input  logic [PKT_W-1:0] pkt_bytes,
   output logic [CNT_W-1:0] remaining,
   output logic             xfer_done,
   output logic             cur_rx,
   output logic             cur_iso,
   output logic             overrun_hit
);

   localparam int unsigned EXT_W = CNT_W - PKT_W;

   logic [CNT_W-1:0] pkt_ext;
   logic [CNT_W-1:0] next_rem;
   logic [PKT_W-1:0] max_pkt_q;
   logic             active;
   logic             accept;
   logic             overrun;
   logic             short_pkt;
   logic             finish;

   initial begin
      assert (CNT_W >= PKT_W) else $error("xdt_countdown: CNT_W must be >= PKT_W");
      assert (PKT_W >= 1)     else $error("xdt_countdown: PKT_W must be >= 1");
   end

   generate
      if (EXT_W == 0) begin : g_same_w
         assign pkt_ext = pkt_bytes;
      end else begin : g_zext
         assign pkt_ext = {{EXT_W{1'b0}}, pkt_bytes};
      end
   endgenerate

   assign accept    = pkt_valid && active && !load;
   assign overrun   = pkt_ext > remaining;
   assign next_rem  = overrun ? '0 : (remaining - pkt_ext);
   assign short_pkt = cur_rx && (pkt_bytes < max_pkt_q);
   assign finish    = (next_rem == '0) || short_pkt;
   assign overrun_hit = accept && overrun;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remaining <= '0;
         xfer_done <= 1'b0;
         active    <= 1'b0;
         cur_rx    <= 1'b0;
         cur_iso   <= 1'b0;
         max_pkt_q <= '0;
      end else if (load) begin
         remaining <= load_bytes;
         xfer_done <= 1'b0;
         active    <= 1'b1;
         cur_rx    <= load_rx;
         cur_iso   <= load_iso;
         max_pkt_q <= load_max_pkt;
      end else if (accept) begin
         remaining <= next_rem;
         xfer_done <= finish;
         active    <= !finish;
      end else begin
         xfer_done <= 1'b0;
      end
   end

   p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (remaining == $past(load_bytes)) && !xfer_done);

   p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !overrun) |=> remaining == ($past(remaining) - $past(pkt_ext)));

   p_tx_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !cur_rx) |-> remaining == '0);

   p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !load) |=> $stable(remaining) && !xfer_done);

   p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_hit |=> (remaining == '0) && xfer_done);

endmodule

// File: rtl/xdt_err_matrix.sv
module xdt_err_matrix
   import xdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cur_rx,
   input  logic             cur_iso,
   input  logic [N_ERR-1:0] ev,
   output logic             dbe_set,
   output logic             txe_set
);

   logic [N_ERR-1:0] hit;
   logic [N_ERR-1:0] dbe_hit;
   logic [N_ERR-1:0] txe_hit;

   generate
      for (genvar i = 0; i < N_ERR; i++) begin : g_src
         localparam err_rule_t RULE = xdt_rule(i);
         logic dir_ok;
         logic type_ok;
         assign dir_ok     = cur_rx ? RULE.on_rx : RULE.on_tx;
         assign type_ok    = cur_iso || !RULE.iso_only;
         assign hit[i]     = ev[i] && dir_ok && type_ok;
         assign dbe_hit[i] = hit[i] && RULE.to_dbe;
         assign txe_hit[i] = hit[i] && RULE.to_txe;
      end
   endgenerate

   assign dbe_set = |dbe_hit;
   assign txe_set = |txe_hit;

   p_tx_no_dbe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_rx |-> !dbe_set);

   p_noniso_no_txe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_iso |-> !txe_set);

   p_full_sets_txe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_iso && ev[ERR_ISO_FULL]) |-> txe_set);

endmodule

// File: rtl/xdt_flags.sv
module xdt_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic dbe_set,
   input  logic txe_set,
   input  logic overrun_hit,
   output logic data_buf_err,
   output logic trans_err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_buf_err <= 1'b0;
         trans_err    <= 1'b0;
      end else if (load) begin
         data_buf_err <= 1'b0;
         trans_err    <= 1'b0;
      end else begin
         data_buf_err <= data_buf_err || dbe_set || overrun_hit;
         trans_err    <= trans_err || txe_set;
      end
   end

   p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !data_buf_err && !trans_err);

   p_dbe_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (data_buf_err && !load) |=> data_buf_err);

   p_txe_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (trans_err && !load) |=> trans_err);

   p_ovr_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_hit && !load) |=> data_buf_err);

endmodule

// File: rtl/xdt_tagger.sv
module xdt_tagger
   import xdt_pkg::*;
#(
   parameter int unsigned CNT_W = 15,
   parameter int unsigned PKT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_bytes,
   input  logic             load_rx,
   input  logic             load_iso,
   input  logic [PKT_W-1:0] load_max_pkt,
   input  logic             pkt_valid,
   input  logic [PKT_W-1:0] pkt_bytes,
   input  logic             ev_overflow,
   input  logic             ev_iso_pkt_err,
   input  logic             ev_iso_fulfill_err,
   output logic [CNT_W-1:0] remaining,
   output logic             xfer_done,
   output logic             data_buf_err,
   output logic             trans_err
);

   logic             cur_rx;
   logic             cur_iso;
   logic             overrun_hit;
   logic             dbe_set;
   logic             txe_set;
   logic [N_ERR-1:0] ev;

   always_comb begin
      ev = '0;
      ev[ERR_OVERFLOW] = ev_overflow;
      ev[ERR_ISO_PKT]  = ev_iso_pkt_err;
      ev[ERR_ISO_FULL] = ev_iso_fulfill_err;
   end

   xdt_countdown #(.CNT_W(CNT_W), .PKT_W(PKT_W)) u_count (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load),
      .load_bytes   (load_bytes),
      .load_rx      (load_rx),
      .load_iso     (load_iso),
      .load_max_pkt (load_max_pkt),
      .pkt_valid    (pkt_valid),
      .pkt_bytes    (pkt_bytes),
      .remaining    (remaining),
      .xfer_done    (xfer_done),
      .cur_rx       (cur_rx),
      .cur_iso      (cur_iso),
      .overrun_hit  (overrun_hit)
   );

   xdt_err_matrix u_matrix (
      .clk     (clk),
      .rst_n   (rst_n),
      .cur_rx  (cur_rx),
      .cur_iso (cur_iso),
      .ev      (ev),
      .dbe_set (dbe_set),
      .txe_set (txe_set)
   );

   xdt_flags u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load),
      .dbe_set      (dbe_set),
      .txe_set      (txe_set),
      .overrun_hit  (overrun_hit),
      .data_buf_err (data_buf_err),
      .trans_err    (trans_err)
   );

   p_done_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (txe_set && !load) |=> trans_err);

endmodule

// File: tb/xdt_tagger_bench.sv
module xdt_tagger_bench;

   localparam int CNT_W = 15;
   localparam int PKT_W = 11;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             load = 1'b0;
   logic [CNT_W-1:0] load_bytes = '0;
   logic             load_rx = 1'b0;
   logic             load_iso = 1'b0;
   logic [PKT_W-1:0] load_max_pkt = '0;
   logic             pkt_valid = 1'b0;
   logic [PKT_W-1:0] pkt_bytes = '0;
   logic             ev_overflow = 1'b0;
   logic             ev_iso_pkt_err = 1'b0;
   logic             ev_iso_fulfill_err = 1'b0;
   logic [CNT_W-1:0] remaining;
   logic             xfer_done;
   logic             data_buf_err;
   logic             trans_err;

   int n_checks = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   xdt_tagger #(.CNT_W(CNT_W), .PKT_W(PKT_W)) u_xdt_tagger (
      .clk                (clk),
      .rst_n              (rst_n),
      .load               (load),
      .load_bytes         (load_bytes),
      .load_rx            (load_rx),
      .load_iso           (load_iso),
      .load_max_pkt       (load_max_pkt),
      .pkt_valid          (pkt_valid),
      .pkt_bytes          (pkt_bytes),
      .ev_overflow        (ev_overflow),
      .ev_iso_pkt_err     (ev_iso_pkt_err),
      .ev_iso_fulfill_err (ev_iso_fulfill_err),
      .remaining          (remaining),
      .xfer_done          (xfer_done),
      .data_buf_err       (data_buf_err),
      .trans_err          (trans_err)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic expect_state(input string req, input int rem, input int done,
                               input int dbe, input int txe);
      check(req, "remaining", int'(remaining), rem);
      check(req, "xfer_done", int'(xfer_done), done);
      check(req, "data_buf_err", int'(data_buf_err), dbe);
      check(req, "trans_err", int'(trans_err), txe);
   endtask

   // every task starts and ends at a falling edge
   task automatic do_load(input int bytes, input bit rx, input bit iso, input int mps,
                          input bit ovf = 1'b0);
      load = 1'b1; load_bytes = CNT_W'(bytes); load_rx = rx; load_iso = iso;
      load_max_pkt = PKT_W'(mps); ev_overflow = ovf;
      @(negedge clk);
      load = 1'b0; ev_overflow = 1'b0;
   endtask

   task automatic step(input bit pv, input int bytes, input bit ovf, input bit ipe, input bit ful);
      pkt_valid = pv; pkt_bytes = PKT_W'(bytes);
      ev_overflow = ovf; ev_iso_pkt_err = ipe; ev_iso_fulfill_err = ful;
      @(negedge clk);
      pkt_valid = 1'b0; pkt_bytes = '0;
      ev_overflow = 1'b0; ev_iso_pkt_err = 1'b0; ev_iso_fulfill_err = 1'b0;
   endtask

   task automatic t_reset;
      expect_state("R1", 0, 0, 0, 0);
      do_load(100, 1'b0, 1'b0, 64);
      expect_state("R1", 100, 0, 0, 0);
   endtask

   task automatic t_tx_countdown;
      do_load(200, 1'b0, 1'b0, 64);
      step(1, 64, 0, 0, 0); expect_state("R2", 136, 0, 0, 0);
      step(1, 64, 0, 0, 0); expect_state("R3", 72, 0, 0, 0);
      step(1, 10, 0, 0, 0); expect_state("R3", 62, 0, 0, 0);
      step(1, 62, 0, 0, 0); expect_state("R3", 0, 1, 0, 0);
      step(0, 0, 0, 0, 0);  expect_state("R5", 0, 0, 0, 0);
      step(1, 5, 0, 0, 0);  expect_state("R5", 0, 0, 0, 0);
   endtask

   task automatic t_rx_short;
      do_load(300, 1'b1, 1'b0, 64);
      step(1, 64, 0, 0, 0); expect_state("R4", 236, 0, 0, 0);
      step(1, 20, 0, 0, 0); expect_state("R4", 216, 1, 0, 0);
      step(1, 64, 0, 0, 0); expect_state("R5", 216, 0, 0, 0);
      do_load(128, 1'b1, 1'b0, 64);
      step(1, 64, 0, 0, 0); expect_state("R4", 64, 0, 0, 0);
      step(1, 64, 0, 0, 0); expect_state("R4", 0, 1, 0, 0);
   endtask

   task automatic t_overrun;
      do_load(30, 1'b0, 1'b0, 64);
      step(1, 40, 0, 0, 0); expect_state("R6", 0, 1, 1, 0);
      do_load(50, 1'b1, 1'b0, 512);
      step(1, 100, 0, 0, 0); expect_state("R6", 0, 1, 1, 0);
   endtask

   task automatic t_overflow;
      do_load(500, 1'b1, 1'b0, 64);
      step(0, 0, 1, 0, 0); expect_state("R7", 500, 0, 1, 0);
      do_load(500, 1'b0, 1'b0, 64);
      step(0, 0, 1, 0, 0); expect_state("R7", 500, 0, 0, 0);
   endtask

   task automatic t_iso_pkt;
      do_load(500, 1'b1, 1'b1, 64);
      step(0, 0, 0, 1, 0); expect_state("R8", 500, 0, 0, 1);
      do_load(500, 1'b1, 1'b0, 64);
      step(0, 0, 0, 1, 0); expect_state("R8", 500, 0, 0, 0);
      do_load(500, 1'b0, 1'b1, 64);
      step(0, 0, 0, 1, 0); expect_state("R8", 500, 0, 0, 0);
   endtask

   task automatic t_fulfill;
      do_load(500, 1'b0, 1'b1, 64);
      step(0, 0, 0, 0, 1); expect_state("R9", 500, 0, 0, 1);
      do_load(500, 1'b1, 1'b1, 64);
      step(0, 0, 0, 0, 1); expect_state("R9", 500, 0, 0, 1);
      do_load(500, 1'b0, 1'b0, 64);
      step(0, 0, 0, 0, 1); expect_state("R9", 500, 0, 0, 0);
   endtask

   task automatic t_sticky;
      do_load(500, 1'b1, 1'b1, 64);
      step(0, 0, 1, 1, 0); expect_state("R10", 500, 0, 1, 1);
      step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
      expect_state("R10", 500, 0, 1, 1);
      do_load(77, 1'b1, 1'b1, 64, 1'b1);
      expect_state("R10", 77, 0, 0, 0);
   endtask

   task automatic t_same_cycle;
      do_load(64, 1'b1, 1'b1, 64);
      step(1, 64, 0, 1, 0); expect_state("R11", 0, 1, 0, 1);
      do_load(128, 1'b0, 1'b1, 64);
      step(1, 64, 0, 0, 1); expect_state("R11", 64, 0, 0, 1);
      step(1, 64, 0, 0, 0); expect_state("R11", 0, 1, 0, 1);
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tx_countdown();
      t_rx_short();
      t_overrun();
      t_overflow();
      t_iso_pkt();
      t_fulfill();
      t_sticky();
      t_same_cycle();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule